// File: doc/BRIEF.md
# Serial Converter Command and Readback Sequencer

This block runs one complete measurement on an external serial analog-to-digital converter. A start request brings in a 3-bit input-mux selection. The block then writes a selection frame to the converter with conversion disabled. It waits a programmable settling time so the analog mux can settle, and writes the same selection again with conversion enabled. After that it clocks the conversion on a dedicated conversion clock pin. Last, it reads the converter's serial output, drops the echoed address and keeps the 12 data bits.

The host raises `start` for one cycle with `mux_sel` valid. It then waits for the one-cycle `done` pulse, at which point `result` carries the new sample in its low 12 bits. The host does not have to wait for `busy` to fall before asserting `start`, because a start request that arrives while a sequence is running is dropped. Any decoding of further channel bits into device selects happens outside this block.

Top module: `adc_seq`

## Requirements
- R1: After reset and whenever the block is idle: `tx_fs_n`=1, `rx_fs_n`=1, `sclk`=1, `conv_clk`=0, `busy`=0, `done`=0. `result` is 0 after reset.
- R2: Each write frame holds `tx_fs_n` low for exactly 6 shift clocks. The converter takes `sdo` at each falling edge of `sclk`, in this order: select bit 2, select bit 1, select bit 0, convert flag, standby flag (0), filler (0). `sdo` changes only while `sclk` is high.
- R3: The first write frame carries convert flag 0 and the second carries convert flag 1. Together the 12 bits shifted are {sel,0,0,0,sel,1,0,0}.
- R4: `tx_fs_n` stays high for exactly SETTLE_CLKS system clocks between the end of the first frame and the start of the second.
- R5: After the second frame, `conv_clk` gives exactly CONV_PULSES (default 14) pulses, and it does so only while both frame strobes are high.
- R6: During readback `rx_fs_n` is low for exactly 15 shift clocks. The converter presents a new bit at each rising edge of `sclk` after the first. The first 3 bits are discarded and the next 12 form the result, MSB first.
- R7: `result` is the 12-bit sample zero-extended to 16 bits. It changes only in the cycle where `done` is high and holds its value otherwise.
- R8: `done` is high for exactly one cycle, and `busy` is low in the cycle after it. A `start` that arrives while `busy` is high is ignored, so that sequence's frames and result are not affected.
- R9: `done` rises 2*HALF_CLKS*(12+CONV_PULSES+15)+SETTLE_CLKS clock edges after the edge that samples `start`.
- R10: Each shift clock period spends HALF_CLKS system clocks high and then HALF_CLKS low, so one full sequence has 27*HALF_CLKS low `sclk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a measurement |
| mux_sel | input | 3 | Converter input-mux selection, latched on start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 16 | Last sample, zero-extended |
| sdo | output | 1 | Serial data to converter |
| sclk | output | 1 | Shift clock, idles high |
| tx_fs_n | output | 1 | Write frame strobe, active low |
| rx_fs_n | output | 1 | Read frame strobe, active low |
| conv_clk | output | 1 | Conversion clock, idles low |
| sdi | input | 1 | Serial data from converter |

## Verification
With HALF_CLKS=4 and SETTLE_CLKS=50, `done` is due 378 edges after the sampling edge of `start`. The bench counts falling system-clock edges from the request and requires `done` to appear at exactly that count. It reads `result` in the same half cycle and confirms one cycle later that `done` and `busy` have dropped. The frame contents, shift-clock counts, settling gap and conversion pulses are collected by edge monitors on the converter-side pins and compared once the sequence ends. Inputs change only on falling system-clock edges. The converter model updates `sdi` on `sclk` rising edges, which come at least HALF_CLKS-1 cycles before the block samples `sdi`.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int HALF_CLKS   = 4,
  parameter int SETTLE_CLKS = 87500,
  parameter int CONV_PULSES = 14,
  parameter int SEL_BITS    = 3,
  parameter int ADDR_BITS   = 3,
  parameter int DATA_BITS   = 12,
  parameter int RES_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SEL_BITS-1:0] mux_sel,
  output logic                busy,
  output logic                done,
  output logic [RES_W-1:0]    result,
  output logic                sdo,
  output logic                sclk,
  output logic                tx_fs_n,
  output logic                rx_fs_n,
  output logic                conv_clk,
  input  logic                sdi
);
  localparam int FRAME_BITS = SEL_BITS + 3;
  localparam int RD_BITS    = ADDR_BITS + DATA_BITS;
  localparam int CELL       = 2 * HALF_CLKS;
  localparam int TMAX       = (CELL > SETTLE_CLKS) ? CELL : SETTLE_CLKS;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int IMAX0      = (CONV_PULSES > RD_BITS) ? CONV_PULSES : RD_BITS;
  localparam int IMAX       = (IMAX0 > FRAME_BITS) ? IMAX0 : FRAME_BITS;
  localparam int IW         = $clog2(IMAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_SETTLE, ST_GO, ST_CONV, ST_READ, ST_DONE
  } st_t;

  st_t                   state;
  logic [TW-1:0]         tick;
  logic [IW-1:0]         idx;
  logic [SEL_BITS-1:0]   sel_q;
  logic [FRAME_BITS-1:0] wsr;
  logic [DATA_BITS-1:0]  shreg;

  wire cell_end = (tick == TW'(CELL - 1));
  wire low_half = (tick >= TW'(HALF_CLKS));
  wire writing  = (state == ST_SEL) || (state == ST_GO);
  wire shifting = writing || (state == ST_READ);

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign tx_fs_n  = !writing;
  assign rx_fs_n  = (state != ST_READ);
  assign sclk     = !(shifting && low_half);
  assign conv_clk = (state == ST_CONV) && !low_half;
  assign sdo      = writing && wsr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tick   <= '0;
      idx    <= '0;
      sel_q  <= '0;
      wsr    <= '0;
      shreg  <= '0;
      result <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            sel_q <= mux_sel;
            wsr   <= {mux_sel, 3'b000};
            tick  <= '0;
            idx   <= '0;
            state <= ST_SEL;
          end
        end
        ST_SEL, ST_GO: begin
          if (cell_end) begin
            tick <= '0;
            wsr  <= {wsr[FRAME_BITS-2:0], 1'b0};
            if (idx == IW'(FRAME_BITS - 1)) begin
              idx   <= '0;
              state <= (state == ST_SEL) ? ST_SETTLE : ST_CONV;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tick == TW'(SETTLE_CLKS - 1)) begin
            tick  <= '0;
            wsr   <= {sel_q, 3'b100};
            state <= ST_GO;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_CONV: begin
          if (cell_end) begin
            tick <= '0;
            if (idx == IW'(CONV_PULSES - 1)) begin
              idx   <= '0;
              state <= ST_READ;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_READ: begin
          if (tick == TW'(HALF_CLKS - 1))
            shreg <= {shreg[DATA_BITS-2:0], sdi};
          if (cell_end) begin
            tick <= '0;
            if (idx == IW'(RD_BITS - 1)) begin
              idx    <= '0;
              result <= RES_W'(shreg);
              state  <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] result,
  input logic        sdo,
  input logic        sclk,
  input logic        tx_fs_n,
  input logic        rx_fs_n,
  input logic        conv_clk
);
  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_fs_n && rx_fs_n && sclk && !conv_clk && !done));
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && !$past(sclk)) |-> $stable(sdo));
  // R5
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_clk |-> (tx_fs_n && rx_fs_n && sclk));
  // R6
  frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tx_fs_n && !rx_fs_n));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R7
  result_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result[15:12] == 4'h0);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .sdo(sdo), .sclk(sclk), .tx_fs_n(tx_fs_n), .rx_fs_n(rx_fs_n),
  .conv_clk(conv_clk)
);

// File: tb/tb_adc_seq.sv
`timescale 1ns/1ps
module tb_adc_seq;
  localparam int H = 4;
  localparam int S = 50;
  localparam int LAT = 2*H*(12+14+15) + S + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b0;
  logic [2:0] mux_sel = '0;
  logic busy, done, sdo, sclk, tx_fs_n, rx_fs_n, conv_clk;
  logic [15:0] result;

  adc_seq #(.HALF_CLKS(H), .SETTLE_CLKS(S)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mux_sel(mux_sel),
    .busy(busy), .done(done), .result(result), .sdo(sdo), .sclk(sclk),
    .tx_fs_n(tx_fs_n), .rx_fs_n(rx_fs_n), .conv_clk(conv_clk), .sdi(sdi));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // converter model
  logic [14:0] word = '0;
  int ridx = 0;
  always @(negedge rx_fs_n) begin ridx = 14; sdi <= word[14]; end
  always @(posedge sclk) if (!rx_fs_n && ridx > 0) begin ridx = ridx - 1; sdi <= word[ridx]; end

  // monitors
  logic [11:0] wbits = '0;
  int wclk = 0, rclk = 0, cpul = 0, gap = 0, gst = 0, slow = 0, ndone = 0;
  always @(negedge sclk) begin
    if (!tx_fs_n) begin wbits = {wbits[10:0], sdo}; wclk++; end
    if (!rx_fs_n) rclk++;
  end
  always @(posedge conv_clk) cpul++;
  always @(negedge clk) begin
    if (!sclk) slow++;
    if (done) ndone++;
    case (gst)
      0: if (!tx_fs_n) gst = 1;
      1: if (tx_fs_n) begin gst = 2; gap = 1; end
      2: if (tx_fs_n) gap++; else gst = 3;
      default: ;
    endcase
  end

  task automatic clear_mon();
    wbits = '0; wclk = 0; rclk = 0; cpul = 0; gap = 0; gst = 0; slow = 0; ndone = 0;
  endtask

  task automatic run_txn(input logic [2:0] ch, input logic [14:0] w, input bit poke);
    int cnt;
    clear_mon();
    word = w;
    @(negedge clk); start = 1'b1; mux_sel = ch;
    @(negedge clk); start = 1'b0; mux_sel = ~ch;
    cnt = 1;
    while (!done && cnt < 2000) begin
      @(negedge clk); cnt++;
      if (poke && cnt == 200) start = 1'b1;
      if (poke && cnt == 201) start = 1'b0;
    end
    check(cnt == LAT, "R9 latency", cnt, LAT);
    check(result == {4'h0, w[11:0]}, "R6/R7 result", result, {4'h0, w[11:0]});
    @(negedge clk);
    check(!done && !busy, "R8 done one cycle", {done, busy}, 0);
    check(ndone == 1, "R8 single done", ndone, 1);
    check(wbits == {ch, 3'b000, ch, 3'b100}, "R2/R3 frame bits", wbits, {ch, 3'b000, ch, 3'b100});
    check(wclk == 12, "R2 write clocks", wclk, 12);
    check(gap == S, "R4 settle gap", gap, S);
    check(cpul == 14, "R5 conversion pulses", cpul, 14);
    check(rclk == 15, "R6 read clocks", rclk, 15);
    check(slow == 27*H, "R10 sclk low time", slow, 27*H);
    check(tx_fs_n && rx_fs_n && sclk && !conv_clk, "R1 idle after run",
          {tx_fs_n, rx_fs_n, sclk, conv_clk}, 4'b1110);
  endtask

  localparam logic [17:0] VEC [6] = '{
    {3'd0, 15'h0000},
    {3'd7, 15'h7FFF},
    {3'd5, 3'b101, 12'hABC},
    {3'd2, 3'b010, 12'h001},
    {3'd6, 3'b111, 12'h800},
    {3'd1, 3'b000, 12'hFFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_fs_n && rx_fs_n && sclk && !conv_clk && !busy && !done && result == 0,
          "R1 reset state", {tx_fs_n, rx_fs_n, sclk, conv_clk, busy, done}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && tx_fs_n && sclk, "R1 idle after reset", {busy, tx_fs_n, sclk}, 3'b011);

    for (int i = 0; i < 6; i++)
      run_txn(VEC[i][17:15], VEC[i][14:0], 1'b0);

    // R8 start during busy is ignored
    run_txn(3'd3, {3'b011, 12'h5A5}, 1'b1);
    repeat (3) @(negedge clk);
    check(!busy && ndone == 1, "R8 ignored start", {busy, 8'(ndone)}, 1);

    // R7 hold after done
    repeat (20) @(negedge clk);
    check(result == 16'h05A5 && !done, "R7 result held", result, 16'h05A5);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule